// File: doc/BRIEF.md
# Calorimeter Pulse Peak Time Reconstructor

This block watches the digitized sample stream of one calorimeter trigger channel, one 10-bit unsigned sample per clock. The samples of the two adjacent channels arrive on the same clock. A sample becomes a peak candidate when three things hold: it lies above a programmable threshold, it is a strict maximum in time against its own channel, and it wins the comparison in space against its neighbours. For an accepted candidate, a parabola is fitted through the peak and its two time neighbours. The vertex of that parabola gives a 7-bit fine time that divides one sample period.

The fit quotient comes from a shared iterative divider that handles one division at a time. A candidate that shows up while the divider is busy is discarded and added to a drop counter. Each finished fit produces one record, marked by a one-cycle valid strobe. The record holds the sample index of the peak since reset, the fine time and the peak amplitude.

Top module: `pulse_peak_timer`

## Requirements
- R1: A sample is a candidate only if its value is strictly greater than `thresh`. A peak equal to the threshold gives no record.
- R2: A candidate must be strictly greater than both the sample before it and the sample after it on the centre channel. A flat top of two equal samples gives no record.
- R3: A candidate must be strictly greater than the left-channel sample of the same index and greater than or equal to the right-channel sample of the same index.
- R4: Take a = peak − previous and b = peak − next, and let q = floor(64·|a−b| / (a+b)). The fine time is 64+q when a ≥ b, saturated to 127, and 64−q otherwise. Equal neighbours therefore give 64.
- R5: `rec_coarse` is the 16-bit index of the peak sample, where the first sample taken after reset is index 0. `rec_amp` is the peak sample value. `rec_valid` stays high for exactly one cycle per record.
- R6: The record appears nine clock edges after the edge that takes in the peak sample.
- R7: A candidate that arrives fewer than 8 samples after the last accepted one is dropped and produces no record. Each drop increments `drop_count` by one, and the counter saturates at its maximum.
- R8: Reset clears the sample history, the divider and `drop_count`. No candidate is formed until three samples have been taken after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| thresh | input | 10 | Amplitude threshold |
| smp_center | input | 10 | Sample of this channel |
| smp_left | input | 10 | Same-index sample of the left neighbour |
| smp_right | input | 10 | Same-index sample of the right neighbour |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_coarse | output | 16 | Peak sample index since reset |
| rec_fine | output | 7 | Fine time within the sample period |
| rec_amp | output | 10 | Peak amplitude |
| drop_count | output | 16 | Candidates lost to a busy divider |

## Verification
The fine-time formula is swept over a 16 by 16 grid of left and right steepness values, from slopes of 1 count up to 399 counts. This grid covers symmetric, strongly skewed and nearly flat shoulders, so rounding and sign errors in the fit become visible. Dedicated streams place peaks exactly at the threshold and one count above it, set the left or right neighbour equal to, above or below the peak, and build a two-sample flat top; each of these separates one comparison from its off-by-one variant. A stream with peak spacings of 7, 8 and longer checks the busy-drop boundary and the drop count, and every record is checked for its index and its nine-edge latency.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

    localparam int SAMPLE_W = 10;
    localparam int FINE_W   = 7;
    localparam int TS_W     = 16;
    localparam int NUM_W    = SAMPLE_W + FINE_W - 1;
    localparam int DEN_W    = SAMPLE_W + 1;
    localparam int SH_W     = DEN_W + FINE_W - 1;
    localparam int IDX_W    = $clog2(FINE_W);
    localparam int FINE_MID = 1 << (FINE_W - 1);
    localparam int FINE_MAX = (1 << FINE_W) - 1;

    typedef logic [SAMPLE_W-1:0] samp_t;
    typedef logic [FINE_W-1:0]   fine_t;
    typedef logic [TS_W-1:0]     tstamp_t;

    typedef struct packed {
        logic             hit;
        logic [NUM_W-1:0] num;
        logic [DEN_W-1:0] den;
        logic             late;
    } fit_req_t;

    typedef struct packed {
        tstamp_t ts;
        samp_t   amp;
        logic    late;
    } fit_tag_t;

    function automatic fine_t map_fine(input fine_t q, input logic late);
        logic [FINE_W:0] sum;
        sum = (FINE_W+1)'(FINE_MID) + {1'b0, q};
        if (late)
            return (sum > (FINE_W+1)'(FINE_MAX)) ? fine_t'(FINE_MAX) : sum[FINE_W-1:0];
        else
            return fine_t'(FINE_MID) - q;
    endfunction

endpackage

// File: rtl/ppt_history.sv
module ppt_history
    import ppt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  samp_t c_in,
    input  samp_t l_in,
    input  samp_t r_in,
    output samp_t prev,
    output samp_t mid,
    output samp_t next,
    output samp_t mid_l,
    output samp_t mid_r,
    output logic  primed
);
    samp_t c_q [3];
    samp_t l_q [2];
    samp_t r_q [2];
    logic [1:0] fill;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) c_q[i] <= '0;
            for (int i = 0; i < 2; i++) begin
                l_q[i] <= '0;
                r_q[i] <= '0;
            end
            fill <= '0;
        end else begin
            c_q[0] <= c_in;
            c_q[1] <= c_q[0];
            c_q[2] <= c_q[1];
            l_q[0] <= l_in;
            l_q[1] <= l_q[0];
            r_q[0] <= r_in;
            r_q[1] <= r_q[0];
            if (fill != 2'd3) fill <= fill + 2'd1;
        end
    end

    assign next   = c_q[0];
    assign mid    = c_q[1];
    assign prev   = c_q[2];
    assign mid_l  = l_q[1];
    assign mid_r  = r_q[1];
    assign primed = (fill == 2'd3);
endmodule

// File: rtl/ppt_peak_detect.sv
module ppt_peak_detect
    import ppt_pkg::*;
(
    input  samp_t    prev,
    input  samp_t    mid,
    input  samp_t    next,
    input  samp_t    mid_l,
    input  samp_t    mid_r,
    input  samp_t    thresh,
    input  logic     primed,
    output fit_req_t req
);
    samp_t rise, fall, skew;

    always_comb begin
        rise = mid - prev;
        fall = mid - next;
        req.hit  = primed && (mid > thresh) && (mid > prev) && (mid > next)
                   && (mid > mid_l) && (mid >= mid_r);
        req.late = (rise >= fall);
        skew     = req.late ? (rise - fall) : (fall - rise);
        req.num  = {skew, {(FINE_W-1){1'b0}}};
        req.den  = {1'b0, rise} + {1'b0, fall};
    end
endmodule

// File: rtl/ppt_divider.sv
module ppt_divider
    import ppt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    input  fit_tag_t         tag_in,
    output logic             busy,
    output logic             done,
    output fine_t            quot,
    output fit_tag_t         tag_out
);
    logic [NUM_W-1:0] rem;
    logic [DEN_W-1:0] dv;
    logic [IDX_W-1:0] idx;
    logic [SH_W-1:0]  trial;
    logic             take;

    always_comb begin
        trial = SH_W'(dv) << idx;
        take  = (SH_W'(rem) >= trial);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem     <= '0;
            dv      <= '0;
            idx     <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            quot    <= '0;
            tag_out <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                rem     <= num;
                dv      <= den;
                idx     <= IDX_W'(FINE_W - 1);
                quot    <= '0;
                tag_out <= tag_in;
                busy    <= 1'b1;
            end else if (busy) begin
                if (take) begin
                    rem       <= rem - trial[NUM_W-1:0];
                    quot[idx] <= 1'b1;
                end
                if (idx == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx - IDX_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pulse_peak_timer.sv
module pulse_peak_timer
    import ppt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [9:0]          thresh,
    input  logic [9:0]          smp_center,
    input  logic [9:0]          smp_left,
    input  logic [9:0]          smp_right,
    output logic                rec_valid,
    output logic [15:0]         rec_coarse,
    output logic [6:0]          rec_fine,
    output logic [9:0]          rec_amp,
    output logic [CNT_W-1:0]    drop_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    samp_t    h_prev, h_mid, h_next, h_left, h_right;
    logic     primed;
    fit_req_t req;
    fit_tag_t tag_in, tag_out;
    tstamp_t  ts;
    fine_t    quot;
    logic     cand_hit, div_busy, div_start, div_done;

    ppt_history u_hist (
        .clk(clk), .rst(rst),
        .c_in(smp_center), .l_in(smp_left), .r_in(smp_right),
        .prev(h_prev), .mid(h_mid), .next(h_next),
        .mid_l(h_left), .mid_r(h_right), .primed(primed)
    );

    ppt_peak_detect u_det (
        .prev(h_prev), .mid(h_mid), .next(h_next),
        .mid_l(h_left), .mid_r(h_right),
        .thresh(thresh), .primed(primed), .req(req)
    );

    assign cand_hit  = req.hit;
    assign div_start = cand_hit && !div_busy;
    assign tag_in    = '{ts: ts - tstamp_t'(2), amp: h_mid, late: req.late};

    ppt_divider u_div (
        .clk(clk), .rst(rst), .start(div_start),
        .num(req.num), .den(req.den), .tag_in(tag_in),
        .busy(div_busy), .done(div_done), .quot(quot), .tag_out(tag_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ts         <= '0;
            drop_count <= '0;
        end else begin
            ts <= ts + tstamp_t'(1);
            if (cand_hit && div_busy && drop_count != CNT_MAX)
                drop_count <= drop_count + CNT_W'(1);
        end
    end

    assign rec_valid  = div_done;
    assign rec_coarse = tag_out.ts;
    assign rec_amp    = tag_out.amp;
    assign rec_fine   = map_fine(quot, tag_out.late);
endmodule

// File: rtl/ppt_checker.sv
module ppt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             hit,
    input logic             busy,
    input logic             start,
    input logic             done,
    input logic             rec_valid,
    input logic [CNT_W-1:0] drops
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assert_start_busy_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    assert_fell_done_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        rec_valid |=> !rec_valid);

    assert_drop_count_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && busy && drops != CNT_MAX) |=> drops == $past(drops) + CNT_W'(1));

    assert_drop_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(hit && busy) |=> $stable(drops));

    assert_quiet_after_reset_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rec_valid && drops == '0));
endmodule

bind pulse_peak_timer ppt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .hit(cand_hit), .busy(div_busy),
    .start(div_start), .done(div_done), .rec_valid(rec_valid), .drops(drop_count)
);

// File: tb/pulse_peak_timer_tb_top.sv
module pulse_peak_timer_tb_top;
    localparam int MAXL = 4096;
    localparam int GAP  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  thresh = '0, smp_center = '0, smp_left = '0, smp_right = '0;
    logic        rec_valid;
    logic [15:0] rec_coarse;
    logic [6:0]  rec_fine;
    logic [9:0]  rec_amp;
    logic [15:0] drop_count;

    int checks = 0, failures = 0;
    int cs [MAXL], ls [MAXL], rs [MAXL];
    int exp_ts [MAXL], exp_fine [MAXL], exp_amp [MAXL];
    int n_exp, n_got, exp_drops, edges;
    bit done_flag = 0;

    always #10 clk = ~clk;

    pulse_peak_timer dut_i (
        .clk(clk), .rst(rst), .thresh(thresh),
        .smp_center(smp_center), .smp_left(smp_left), .smp_right(smp_right),
        .rec_valid(rec_valid), .rec_coarse(rec_coarse), .rec_fine(rec_fine),
        .rec_amp(rec_amp), .drop_count(drop_count)
    );

    always @(posedge clk) edges <= rst ? 0 : edges + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && rec_valid) begin
            if (n_got < n_exp) begin
                check(rec_coarse == 16'(exp_ts[n_got]), "R5 coarse", rec_coarse, exp_ts[n_got]);
                check(rec_fine == 7'(exp_fine[n_got]), "R4 fine", rec_fine, exp_fine[n_got]);
                check(rec_amp == 10'(exp_amp[n_got]), "R5 amp", rec_amp, exp_amp[n_got]);
                check(edges == exp_ts[n_got] + 10, "R6 latency", edges, exp_ts[n_got] + 10);
            end else begin
                check(0, "R1/R2/R3 unexpected record", rec_coarse, -1);
            end
            n_got++;
        end
    end

    task automatic clear_stream();
        for (int i = 0; i < MAXL; i++) begin
            cs[i] = 0; ls[i] = 0; rs[i] = 0;
        end
    endtask

    task automatic put_pulse(input int p, input int amp, input int a, input int b,
                             input int lft, input int rgt);
        cs[p] = amp; cs[p-1] = amp - a; cs[p+1] = amp - b;
        ls[p] = lft; rs[p] = rgt;
    endtask

    task automatic build_expect(input int len, input int thr);
        int last = -1000;
        n_exp = 0; exp_drops = 0;
        for (int c = 1; c < len - 1; c++) begin
            if (cs[c] > thr && cs[c] > cs[c-1] && cs[c] > cs[c+1]
                && cs[c] > ls[c] && cs[c] >= rs[c]) begin
                if (c - last >= GAP) begin
                    int a = cs[c] - cs[c-1];
                    int b = cs[c] - cs[c+1];
                    int d = (a >= b) ? a - b : b - a;
                    int q = (64 * d) / (a + b);
                    int f = (a >= b) ? 64 + q : 64 - q;
                    if (f > 127) f = 127;
                    exp_ts[n_exp] = c; exp_fine[n_exp] = f; exp_amp[n_exp] = cs[c];
                    n_exp++;
                    last = c;
                end else begin
                    exp_drops++;
                end
            end
        end
    endtask

    task automatic run_stream(input int used, input int thr, input string name);
        int len = used + 14;
        build_expect(len, thr);
        n_got = 0;
        thresh = 10'(thr);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rec_valid == 1'b0, "R8 reset valid", rec_valid, 0);
        check(drop_count == 16'd0, "R8 reset drops", drop_count, 0);
        rst = 1'b0;
        for (int k = 0; k < len; k++) begin
            if (k > 0) @(negedge clk);
            smp_center = 10'(cs[k]); smp_left = 10'(ls[k]); smp_right = 10'(rs[k]);
        end
        @(negedge clk);
        check(n_got == n_exp, "R7 record count", n_got, n_exp);
        check(drop_count == 16'(exp_drops), "R7 drop count", drop_count, exp_drops);
        $display("stream %s: %0d records", name, n_exp);
    endtask

    initial begin
        int slope [16] = '{1, 2, 3, 4, 5, 7, 9, 12, 16, 25, 40, 64, 100, 150, 250, 399};
        int p;

        // R4: fit sweep, spacing exactly at the accept boundary (R7)
        clear_stream();
        p = 2;
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) begin
                put_pulse(p, 500, slope[i], slope[j], 0, 0);
                p += GAP;
            end
        run_stream(p, 100, "fit_sweep");

        // R1: threshold strictness, plus full-scale peak
        clear_stream();
        put_pulse(3, 300, 10, 10, 0, 0);
        put_pulse(15, 301, 10, 10, 0, 0);
        put_pulse(27, 1023, 23, 5, 0, 0);
        run_stream(32, 300, "threshold");

        // R3: space comparison against neighbours
        clear_stream();
        put_pulse(3, 500, 10, 20, 500, 0);
        put_pulse(15, 500, 20, 10, 0, 500);
        put_pulse(27, 500, 30, 10, 499, 0);
        put_pulse(39, 500, 10, 30, 0, 501);
        run_stream(44, 50, "space");

        // R2: flat top and one-sided maxima
        clear_stream();
        cs[3] = 490; cs[4] = 500; cs[5] = 500; cs[6] = 490;
        cs[15] = 490; cs[16] = 500; cs[17] = 510;
        put_pulse(30, 600, 15, 15, 0, 0);
        run_stream(36, 50, "time");

        // R7: busy drops at spacing 7, accepts at 8 and beyond
        clear_stream();
        put_pulse(2, 500, 100, 100, 0, 0);
        put_pulse(9, 500, 100, 100, 0, 0);
        put_pulse(18, 500, 50, 150, 0, 0);
        put_pulse(26, 500, 150, 50, 0, 0);
        put_pulse(33, 500, 100, 100, 0, 0);
        put_pulse(38, 500, 80, 100, 0, 0);
        run_stream(42, 50, "busy");

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done_flag) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule